// File: doc/BRIEF.md
# UART Interrupt Source Prioritizer and Identifier

This block merges the four interrupt causes of a UART channel into one interrupt line and an 8-bit identification value that the CPU reads to find out why it was interrupted. The causes, from most to least urgent, are a receiver line error, received data available (or a character timeout in FIFO mode), the transmit holding stage being empty, and a modem status change. Each cause has its own enable bit. Only the most urgent enabled cause is encoded.

The transmit-empty cause is the only one this block stores. It is armed when the holding stage goes from loaded to empty. It is dropped by a new load, or by an identification read that reported it. In FIFO mode a lightly used transmit queue holds back this indication until the transmitter reaches the final stop bit of the current character. This avoids an interrupt for every byte. While the CPU is reading the identification value, the value stays fixed, but the sources underneath keep updating.

Top module: `uart_int_id`

## Requirements
- R1: Codes in id_code[3:0], in priority order from highest to lowest: line error 4'b0110, received data 4'b0100, character timeout 4'b1100, transmit empty 4'b0010, modem change 4'b0000. With nothing pending the code is 4'b0001.
- R2: Bit 0 is low exactly when a cause is reported. Bits 5:4 are always zero. Bits 7:6 both equal fifo_en. After reset id_code is 8'h01 and irq is low.
- R3: The character timeout is reported only when fifo_en is high. With fifo_en low it is ignored, and bit 3 stays zero.
- R4: Enable bits: src_en[0] covers received data and timeout, src_en[1] covers transmit empty, src_en[2] covers line error, src_en[3] covers modem change. A disabled cause is neither encoded nor drives irq.
- R5: irq is registered. It goes high on the clock edge after an enabled cause is present, and goes low on the edge after none remains.
- R6: While id_rd stays high, id_code holds the value shown in the first cycle of the read. The frozen value stays visible until one cycle after id_rd falls.
- R7: Outside the delayed case, transmit empty becomes pending on the edge where hold_empty is first seen high after being low. A hold_wr pulse clears it on the next edge, and takes precedence over any setting event.
- R8: When id_rd falls, the pending transmit empty is cleared if the frozen code was 4'b0010. A read that reported any other code leaves it pending.
- R9: With fifo_en high, if txq_two has not been high since the previous empty rise, a new empty rise waits. Transmit empty then becomes pending on the edge of the next tx_last_stop pulse. A hold_wr during the wait cancels it.
- R10: The first empty rise after reset or after any change of fifo_en is reported immediately, without waiting.
- R11: A change of fifo_en while a delayed indication is waiting makes transmit empty pending on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_en | input | 4 | Per-cause enable mask |
| fifo_en | input | 1 | FIFO mode active |
| line_err | input | 1 | Receiver line error condition |
| rx_avail | input | 1 | Received data available condition |
| rx_tmo | input | 1 | Receive character timeout condition |
| modem_chg | input | 1 | Modem status change condition |
| hold_empty | input | 1 | Transmit holding stage or queue is empty |
| txq_two | input | 1 | Transmit queue currently holds two or more bytes |
| tx_last_stop | input | 1 | Pulse when the transmitter reaches the final stop bit |
| hold_wr | input | 1 | Write strobe to the transmit holding stage |
| id_rd | input | 1 | Identification read strobe (level, held for the read) |
| irq | output | 1 | Registered interrupt request |
| id_code | output | 8 | Identification value |

## Verification
The hardest states to reach are the delayed transmit-empty indication and the ways it ends. One is a tx_last_stop pulse. Another is a hold_wr that cancels it. A third is a change of fifo_en that releases it early. Each needs a FIFO-mode load after the first indication following a mode change, with txq_two kept low. The directed stimulus steps through that exact order. A read that freezes the code while a lower or higher priority cause appears underneath is driven explicitly. A long random phase follows, with id_rd held for varying lengths. In that phase a behavioural model is compared against the outputs on every clock.

// File: rtl/uart_int_id.sv
module uart_int_id (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] src_en,
  input  logic       fifo_en,
  input  logic       line_err,
  input  logic       rx_avail,
  input  logic       rx_tmo,
  input  logic       modem_chg,
  input  logic       hold_empty,
  input  logic       txq_two,
  input  logic       tx_last_stop,
  input  logic       hold_wr,
  input  logic       id_rd,
  output logic       irq,
  output logic [7:0] id_code
);
  localparam logic [3:0] C_NONE = 4'b0001;
  localparam logic [3:0] C_LINE = 4'b0110;
  localparam logic [3:0] C_DATA = 4'b0100;
  localparam logic [3:0] C_TMO  = 4'b1100;
  localparam logic [3:0] C_TXE  = 4'b0010;
  localparam logic [3:0] C_MDM  = 4'b0000;

  logic       rd_q, empty_q, mode_q;
  logic       pend, wait_q, first_q, seen2, irq_q;
  logic [7:0] frozen;
  logic [3:0] code;
  logic [7:0] live;

  wire line_on = line_err & src_en[2];
  wire data_on = rx_avail & src_en[0];
  wire rx_on   = (rx_avail | (rx_tmo & fifo_en)) & src_en[0];
  wire tx_on   = pend & src_en[1];
  wire ms_on   = modem_chg & src_en[3];

  always_comb begin
    if (line_on)      code = C_LINE;
    else if (data_on) code = C_DATA;
    else if (rx_on)   code = C_TMO;
    else if (tx_on)   code = C_TXE;
    else if (ms_on)   code = C_MDM;
    else              code = C_NONE;
  end

  assign live    = {fifo_en, fifo_en, 2'b00, code};
  assign id_code = rd_q ? frozen : live;
  assign irq     = irq_q;

  wire rise   = hold_empty & ~empty_q;
  wire mchg   = fifo_en ^ mode_q;
  wire fast   = ~fifo_en | first_q | seen2 | txq_two;
  wire rd_clr = rd_q & ~id_rd & (frozen[3:0] == C_TXE);
  wire set_ev = (rise & fast) | (wait_q & (tx_last_stop | mchg));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      empty_q <= 1'b1;
      mode_q  <= 1'b0;
      pend    <= 1'b0;
      wait_q  <= 1'b0;
      first_q <= 1'b1;
      seen2   <= 1'b0;
      irq_q   <= 1'b0;
      frozen  <= {2'b00, 2'b00, C_NONE};
    end else begin
      rd_q    <= id_rd;
      empty_q <= hold_empty;
      mode_q  <= fifo_en;
      irq_q   <= line_on | rx_on | tx_on | ms_on;

      if (id_rd && !rd_q) frozen <= live;

      if (hold_wr)     pend <= 1'b0;
      else if (rd_clr) pend <= 1'b0;
      else if (set_ev) pend <= 1'b1;

      if (hold_wr)                          wait_q <= 1'b0;
      else if (rise && !fast)               wait_q <= 1'b1;
      else if (tx_last_stop || mchg)        wait_q <= 1'b0;

      if (mchg)               first_q <= 1'b1;
      else if (rise && fast)  first_q <= 1'b0;

      if (rise)         seen2 <= 1'b0;
      else if (txq_two) seen2 <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_int_id_chk.sv
module uart_int_id_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] src_en,
  input logic       fifo_en,
  input logic       line_err,
  input logic       hold_wr,
  input logic       id_rd,
  input logic       irq,
  input logic [7:0] id_code
);
  p_line_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    line_err && src_en[2] && !$past(id_rd) |-> id_code[3:0] == 4'b0110);

  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    id_code[5:4] == 2'b00);

  p_no_tmo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en && !$past(id_rd) |-> !id_code[3] && id_code[7:6] == 2'b00);

  p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !src_en[2] && !$past(id_rd) |-> id_code[3:0] != 4'b0110);

  p_irq_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(id_rd) && !id_code[0] |=> irq);

  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    id_rd && $past(id_rd) |-> $stable(id_code));

  p_wr_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_wr && !id_rd |=> id_code[3:0] != 4'b0010);
endmodule

bind uart_int_id uart_int_id_chk u_chk (
  .clk(clk), .rst_n(rst_n), .src_en(src_en), .fifo_en(fifo_en),
  .line_err(line_err), .hold_wr(hold_wr), .id_rd(id_rd),
  .irq(irq), .id_code(id_code)
);

// File: tb/uart_int_id_tb.sv
module uart_int_id_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] src_en = 4'h0;
  logic       fifo_en = 1'b0, line_err = 1'b0, rx_avail = 1'b0, rx_tmo = 1'b0;
  logic       modem_chg = 1'b0, hold_empty = 1'b1, txq_two = 1'b0;
  logic       tx_last_stop = 1'b0, hold_wr = 1'b0, id_rd = 1'b0;
  logic       irq;
  logic [7:0] id_code;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  uart_int_id u_dut (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .fifo_en(fifo_en),
    .line_err(line_err), .rx_avail(rx_avail), .rx_tmo(rx_tmo),
    .modem_chg(modem_chg), .hold_empty(hold_empty), .txq_two(txq_two),
    .tx_last_stop(tx_last_stop), .hold_wr(hold_wr), .id_rd(id_rd),
    .irq(irq), .id_code(id_code)
  );

  // behavioural reference
  bit m_rdq, m_eq, m_mode, m_pend, m_wait, m_first, m_seen2, m_irq;
  bit [7:0] m_frz;

  function automatic bit [7:0] m_live();
    bit [3:0] c;
    bit rxen = src_en[0];
    if (line_err && src_en[2])                c = 4'b0110;
    else if (rx_avail && rxen)                c = 4'b0100;
    else if (rx_tmo && fifo_en && rxen)       c = 4'b1100;
    else if (m_pend && src_en[1])             c = 4'b0010;
    else if (modem_chg && src_en[3])          c = 4'b0000;
    else                                      c = 4'b0001;
    return {fifo_en, fifo_en, 2'b00, c};
  endfunction

  function automatic bit [7:0] m_id();
    return m_rdq ? m_frz : m_live();
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rdq = 0; m_eq = 1; m_mode = 0; m_pend = 0; m_wait = 0;
      m_first = 1; m_seen2 = 0; m_irq = 0; m_frz = 8'h01;
    end else begin
      bit rise, chg, quick, np, nw, nf, ns;
      rise  = hold_empty && !m_eq;
      chg   = fifo_en != m_mode;
      quick = !fifo_en || m_first || m_seen2 || txq_two;
      np = m_pend; nw = m_wait; nf = m_first; ns = m_seen2;
      if (rise && quick) begin np = 1; nf = 0; end
      if (m_wait && (tx_last_stop || chg)) begin np = 1; nw = 0; end
      if (rise && !quick) nw = 1;
      if (chg) nf = 1;
      if (m_rdq && !id_rd && m_frz[3:0] == 4'b0010) np = 0;
      if (hold_wr) begin np = 0; nw = 0; end
      if (rise) ns = 0; else if (txq_two) ns = 1;
      m_irq = !m_live()[0];
      if (id_rd && !m_rdq) m_frz = m_live();
      m_pend = np; m_wait = nw; m_first = nf; m_seen2 = ns;
      m_rdq = id_rd; m_eq = hold_empty; m_mode = fifo_en;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      total++;
      if (id_code !== m_id()) begin
        bad++;
        $display("FAIL R2 model id_code act=%h exp=%h t=%0t", id_code, m_id(), $time);
      end
      total++;
      if (irq !== m_irq) begin
        bad++;
        $display("FAIL R5 model irq act=%b exp=%b t=%0t", irq, m_irq, $time);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic load_then_empty();
    hold_wr = 1; hold_empty = 0; step(1);
    hold_wr = 0; step(1);
    hold_empty = 1; step(1);
  endtask

  initial begin
    step(3);
    rst_n = 1; step(2);
    chk("R2 reset id", id_code, 8'h01);
    chk("R2 reset irq", {7'd0, irq}, 8'h00);

    src_en = 4'hF; modem_chg = 1; #1;
    chk("R1 modem code", id_code, 8'h00);
    chk("R5 irq before edge", {7'd0, irq}, 8'h00);
    step(1);
    chk("R5 irq after edge", {7'd0, irq}, 8'h01);

    load_then_empty();
    chk("R7 empty pending", id_code, 8'h02);
    rx_avail = 1; #1;
    chk("R1 data over empty", id_code, 8'h04);
    rx_avail = 0; rx_tmo = 1; #1;
    chk("R3 timeout ignored", id_code, 8'h02);
    rx_tmo = 0; line_err = 1; #1;
    chk("R1 line highest", id_code, 8'h06);
    src_en = 4'b1011; #1;
    chk("R4 line masked", id_code, 8'h02);
    src_en = 4'h0; step(1);
    chk("R4 all masked id", id_code, 8'h01);
    chk("R4 all masked irq", {7'd0, irq}, 8'h00);
    src_en = 4'hF; step(1);

    id_rd = 1; step(1);
    line_err = 0; #1;
    chk("R6 frozen", id_code, 8'h06);
    step(2);
    chk("R6 still frozen", id_code, 8'h06);
    id_rd = 0; #1;
    chk("R6 held after fall", id_code, 8'h06);
    step(1);
    chk("R8 other read keeps empty", id_code, 8'h02);
    id_rd = 1; step(1);
    id_rd = 0; step(1);
    chk("R8 read clears empty", id_code, 8'h00);
    modem_chg = 0; step(1);

    fifo_en = 1; step(1);
    chk("R2 fifo bits", id_code, 8'hC1);
    rx_tmo = 1; #1;
    chk("R3 timeout code", id_code, 8'hCC);
    rx_tmo = 0; step(1);
    load_then_empty();
    chk("R10 first immediate", id_code, 8'hC2);
    hold_wr = 1; hold_empty = 0; step(1);
    chk("R7 write clears", id_code, 8'hC1);
    hold_wr = 0; step(1);
    hold_empty = 1; step(1);
    chk("R9 waiting", id_code, 8'hC1);
    step(3);
    chk("R9 still waiting", id_code, 8'hC1);
    tx_last_stop = 1; step(1);
    tx_last_stop = 0;
    chk("R9 released by stop", id_code, 8'hC2);

    hold_wr = 1; hold_empty = 0; txq_two = 1; step(1);
    hold_wr = 0; txq_two = 0; step(2);
    hold_empty = 1; step(1);
    chk("R9 two bytes immediate", id_code, 8'hC2);

    load_then_empty();
    chk("R9 wait again", id_code, 8'hC1);
    hold_wr = 1; hold_empty = 0; step(1);
    hold_wr = 0; hold_empty = 1; step(1);
    tx_last_stop = 1; step(1);
    tx_last_stop = 0;
    chk("R9 wr cancel then new wait", id_code, 8'hC2);
    hold_wr = 1; hold_empty = 0; step(1);
    hold_wr = 0; step(1);
    hold_empty = 1; step(1);
    chk("R11 waiting", id_code, 8'hC1);
    fifo_en = 0; step(1);
    chk("R11 mode change releases", id_code, 8'h02);

    for (int i = 0; i < 4000; i++) begin
      line_err     = ($urandom_range(0, 9) == 0);
      rx_avail     = ($urandom_range(0, 6) == 0);
      rx_tmo       = ($urandom_range(0, 9) == 0);
      modem_chg    = ($urandom_range(0, 9) == 0);
      txq_two      = ($urandom_range(0, 19) == 0);
      tx_last_stop = ($urandom_range(0, 9) == 0);
      hold_wr      = ($urandom_range(0, 14) == 0);
      if (hold_wr) hold_empty = 0;
      else if ($urandom_range(0, 7) == 0) hold_empty = 1;
      if ($urandom_range(0, 6) == 0) id_rd = ~id_rd;
      if ($urandom_range(0, 99) == 0) fifo_en = ~fifo_en;
      if ($urandom_range(0, 49) == 0) src_en = 4'($urandom);
      step(1);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule